// File: doc/BRIEF.md
# Timer-Paced Serial ADC Sampler

This block collects samples from an external serial ADC at a fixed rate without any per-sample help from the host. A down-counting period timer reloads itself every PERIOD system cycles. Each time it reaches zero, the block lowers chip select, runs the serial clock for one 22-bit word (or for a 32-clock frame in the wide framing mode) and shifts in the data line. It then writes the sample into an on-chip buffer.

The buffer has two banks. Samples fill one bank until BLOCKLEN samples are stored. The block then raises a single done interrupt, reports which bank is complete and carries on filling the other bank. The host only needs to service the block once per block of samples. Capture starts when a start bit is written. A stop request lets the current block finish and then halts capture.

Registers are on a small word-addressed port. Address 0 is control: bit0 start, bit1 stop request, bit2 wide framing, bit3 sample on falling edge. A read of address 0 returns the mode bits and the running flag in bit0. Address 1 is PERIOD, address 2 is DIVHALF (serial clock half period in system cycles) and address 3 is BLOCKLEN. Address 4 is status: bit0 done, bit1 ready bank, bit2 overrun, bit3 running. Writing 1 to bit0 or bit2 of address 4 clears that bit.

Top module: `spi_adc_pacer`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the interrupt is low and status reads 0. PERIOD reads 480, DIVHALF reads 1 and BLOCKLEN reads 1000.
- R2: In narrow mode, one transfer gives exactly 22 rising serial clock edges, and chip select stays low across all of them without releasing between bits. The serial clock idles low.
- R3: While running, consecutive transfers start exactly PERIOD system cycles apart. The first transfer starts PERIOD cycles after the start write.
- R4: In the default sampling mode (bit3 = 0), data is taken on rising serial clock edges, most significant bit first. Each word is stored right-justified in a 32-bit entry with bits 31:22 zero.
- R5: With control bit3 = 1, data is taken on falling serial clock edges instead, still most significant bit first.
- R6: In wide mode (control bit2 = 1), a frame has 32 serial clocks. Chip select is low for the first 22 and high for the last 10. Only the 22 bits taken while chip select was low are stored.
- R7: After BLOCKLEN samples, the done interrupt rises and status bit1 gives the bank just filled. Bank 0 occupies buffer addresses 0 to 1023 and bank 1 occupies addresses 1024 to 2047. Successive blocks alternate between the banks.
- R8: Writing 1 to status bit0 clears the interrupt. Writing 0 there leaves it set.
- R9: A timer expiry that arrives while a transfer is in progress is dropped and sets the sticky overrun bit (status bit2). Writing 1 to status bit2 clears it.
- R10: A stop request does not end capture at once. The current block completes, running then drops, and no further transfers start.
- R11: Each serial clock phase (high or low) lasts DIVHALF system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irqDone | output | 1 | Block-done interrupt |
| spiSclk | output | 1 | Serial clock to the ADC |
| spiCsN | output | 1 | Active-low chip select |
| spiMiso | input | 1 | Serial data from the ADC |
| bufRdAddr | input | 11 | Buffer read address, bank in the top bit |
| bufRdData | output | 32 | Buffer read data, one cycle after the address |

## Verification
The assertions assume DIVHALF is at least 1 and BLOCKLEN lies between 1 and the bank depth. They also assume the mode, period and length registers are changed only while capture is stopped. The stimulus writes configuration before every start and waits for running to clear before reconfiguring. The ADC model changes its data line only on the serial clock edge opposite to the sampling edge, so the data is stable for DIVHALF cycles around every capture. Only the overrun scenario uses a period shorter than the frame, so that expiries are dropped on purpose.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
  typedef struct packed {
    logic go;         // begin a frame now
    logic wide;       // 32-clock frame with 22-clock select window
    logic onFalling;  // take data on falling serial edges
    logic store;      // write captured word into buffer
  } ctlStrobe_t;
endpackage

// File: rtl/spi_adc_ctrl.sv
module spi_adc_ctrl
  import spi_adc_pkg::*;
#(
  parameter int TIMER_W    = 16,
  parameter int BANK_AW    = 10,
  parameter int DIV_W      = 8,
  parameter int DEF_PERIOD = 480,
  parameter int DEF_BLOCK  = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               dpBusy,
  input  logic               dpWordDone,
  output ctlStrobe_t         strb,
  output logic [BANK_AW:0]   storeAddr,
  output logic [DIV_W-1:0]   divHalf,
  output logic               irqDone
);
  localparam int BLK_W = BANK_AW + 1;

  logic [TIMER_W-1:0] periodR, tmr;
  logic [DIV_W-1:0]   divHalfR;
  logic [BLK_W-1:0]   blockLenR, idx;
  logic wideR, fallR, running, stopPend, bank, readyBank, doneIrq, overrun;
  logic tick, blockEnd;

  logic wrCtrl, wrStat;
  assign wrCtrl = regWe && (regAddr == 3'd0);
  assign wrStat = regWe && (regAddr == 3'd4);

  assign tick     = running && (tmr == '0);
  assign blockEnd = dpWordDone && (idx == blockLenR - 1'b1);

  assign strb.go        = tick && !dpBusy;
  assign strb.wide      = wideR;
  assign strb.onFalling = fallR;
  assign strb.store     = dpWordDone;
  assign storeAddr      = {bank, idx[BANK_AW-1:0]};
  assign divHalf        = divHalfR;
  assign irqDone        = doneIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodR   <= TIMER_W'(DEF_PERIOD);
      divHalfR  <= DIV_W'(1);
      blockLenR <= BLK_W'(DEF_BLOCK);
      wideR     <= 1'b0;
      fallR     <= 1'b0;
      running   <= 1'b0;
      stopPend  <= 1'b0;
      tmr       <= '0;
      idx       <= '0;
      bank      <= 1'b0;
      readyBank <= 1'b0;
      doneIrq   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (running) tmr <= tick ? periodR - 1'b1 : tmr - 1'b1;
      if (regWe) begin
        case (regAddr)
          3'd1: periodR   <= regWdata[TIMER_W-1:0];
          3'd2: divHalfR  <= regWdata[DIV_W-1:0];
          3'd3: blockLenR <= regWdata[BLK_W-1:0];
          default: ;
        endcase
      end
      if (wrCtrl) begin
        wideR <= regWdata[2];
        fallR <= regWdata[3];
        if (regWdata[0] && !running) begin
          running  <= 1'b1;
          stopPend <= 1'b0;
          idx      <= '0;
          tmr      <= periodR - 1'b1;
        end
        if (regWdata[1] && running) stopPend <= 1'b1;
      end
      if (wrStat && regWdata[0]) doneIrq <= 1'b0;
      if (wrStat && regWdata[2]) overrun <= 1'b0;
      if (tick && dpBusy) overrun <= 1'b1;
      if (dpWordDone) begin
        if (blockEnd) begin
          idx       <= '0;
          doneIrq   <= 1'b1;
          readyBank <= bank;
          bank      <= ~bank;
          if (stopPend) begin
            running  <= 1'b0;
            stopPend <= 1'b0;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (regAddr)
      3'd0:    regRdata = {28'd0, fallR, wideR, 1'b0, running};
      3'd1:    regRdata = 32'(periodR);
      3'd2:    regRdata = 32'(divHalfR);
      3'd3:    regRdata = 32'(blockLenR);
      3'd4:    regRdata = {28'd0, running, overrun, readyBank, doneIrq};
      default: regRdata = '0;
    endcase
  end

  // R9: overrun holds until software clears it
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !(wrStat && regWdata[2])) |=> overrun);
  // R7: interrupt only rises on the word that closes a block
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> $past(dpWordDone));
  // R7: stored index never passes the programmed length
  p_store_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |-> (idx < blockLenR));
  // R10: capture halts only at a block boundary
  p_stop_at_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(dpWordDone));
endmodule

// File: rtl/spi_adc_datapath.sv
module spi_adc_datapath
  import spi_adc_pkg::*;
#(
  parameter int WORD_BITS  = 22,
  parameter int FRAME_BITS = 32,
  parameter int BANK_AW    = 10,
  parameter int DIV_W      = 8,
  parameter int DATA_W     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [BANK_AW:0]   storeAddr,
  input  logic [DIV_W-1:0]   divHalf,
  output logic               dpBusy,
  output logic               dpWordDone,
  output logic               spiSclk,
  output logic               spiCsN,
  input  logic               spiMiso,
  input  logic [BANK_AW:0]   bufRdAddr,
  output logic [DATA_W-1:0]  bufRdData
);
  localparam int ENTRIES = 2 << BANK_AW;
  localparam int EDGE_W  = $clog2(2 * FRAME_BITS + 1);
  localparam logic [EDGE_W-1:0] NARROW_LAST = EDGE_W'(2 * WORD_BITS - 1);
  localparam logic [EDGE_W-1:0] WIDE_LAST   = EDGE_W'(2 * FRAME_BITS - 1);

  logic                  active, sclkR, wideL, fallL, wordDone;
  logic [DIV_W-1:0]      divCnt, divL;
  logic [EDGE_W-1:0]     edgeCnt;
  logic [FRAME_BITS-1:0] sh, shNext, shCap;
  logic [WORD_BITS-1:0]  capWord;
  logic                  edgeNow, sampleNow, lastEdge;
  logic [DATA_W-1:0]     mem [ENTRIES];

  assign edgeNow   = active && (divCnt == divL - 1'b1);
  assign sampleNow = fallL ? sclkR : !sclkR;
  assign lastEdge  = edgeCnt == (wideL ? WIDE_LAST : NARROW_LAST);
  assign shNext    = {sh[FRAME_BITS-2:0], spiMiso};
  assign shCap     = sampleNow ? shNext : sh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      spiCsN   <= 1'b1;
      sclkR    <= 1'b0;
      divCnt   <= '0;
      divL     <= DIV_W'(1);
      edgeCnt  <= '0;
      sh       <= '0;
      capWord  <= '0;
      wordDone <= 1'b0;
      wideL    <= 1'b0;
      fallL    <= 1'b0;
    end else begin
      wordDone <= 1'b0;
      if (strb.go && !active) begin
        active  <= 1'b1;
        spiCsN  <= 1'b0;
        sclkR   <= 1'b0;
        divCnt  <= '0;
        edgeCnt <= '0;
        sh      <= '0;
        wideL   <= strb.wide;
        fallL   <= strb.onFalling;
        divL    <= divHalf;
      end else if (active) begin
        if (edgeNow) begin
          divCnt  <= '0;
          sclkR   <= ~sclkR;
          edgeCnt <= edgeCnt + 1'b1;
          sh      <= shCap;
          if (lastEdge) begin
            active   <= 1'b0;
            spiCsN   <= 1'b1;
            wordDone <= 1'b1;
            capWord  <= wideL ? shCap[FRAME_BITS-1 -: WORD_BITS] : shCap[WORD_BITS-1:0];
          end else if (wideL && edgeCnt == NARROW_LAST) begin
            spiCsN <= 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.store) mem[storeAddr] <= {(DATA_W - WORD_BITS)'(0), capWord};
    bufRdData <= mem[bufRdAddr];
  end

  assign spiSclk    = sclkR;
  assign dpWordDone = wordDone;
  assign dpBusy     = active || wordDone;

  // R1: serial clock rests low outside a frame
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !spiSclk);
  // R2: narrow frames keep select low for every bit
  p_cs_narrow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (active && !wideL) |-> !spiCsN);
  // R6: select is released whenever no frame runs
  p_cs_released_r6: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> spiCsN);
  // R6: a frame never runs past its own edge count
  p_edge_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (edgeCnt <= WIDE_LAST));
endmodule

// File: rtl/spi_adc_pacer.sv
module spi_adc_pacer
  import spi_adc_pkg::*;
#(
  parameter int WORD_BITS  = 22,
  parameter int FRAME_BITS = 32,
  parameter int BANK_AW    = 10,
  parameter int TIMER_W    = 16,
  parameter int DIV_W      = 8,
  parameter int DEF_PERIOD = 480,
  parameter int DEF_BLOCK  = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic               irqDone,
  output logic               spiSclk,
  output logic               spiCsN,
  input  logic               spiMiso,
  input  logic [BANK_AW:0]   bufRdAddr,
  output logic [31:0]        bufRdData
);
  ctlStrobe_t         strb;
  logic [BANK_AW:0]   storeAddr;
  logic [DIV_W-1:0]   divHalf;
  logic               dpBusy, dpWordDone;

  spi_adc_ctrl #(
    .TIMER_W(TIMER_W), .BANK_AW(BANK_AW), .DIV_W(DIV_W),
    .DEF_PERIOD(DEF_PERIOD), .DEF_BLOCK(DEF_BLOCK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dpBusy(dpBusy),
    .dpWordDone(dpWordDone), .strb(strb), .storeAddr(storeAddr),
    .divHalf(divHalf), .irqDone(irqDone)
  );

  spi_adc_datapath #(
    .WORD_BITS(WORD_BITS), .FRAME_BITS(FRAME_BITS), .BANK_AW(BANK_AW),
    .DIV_W(DIV_W), .DATA_W(32)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .storeAddr(storeAddr),
    .divHalf(divHalf), .dpBusy(dpBusy), .dpWordDone(dpWordDone),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMiso(spiMiso),
    .bufRdAddr(bufRdAddr), .bufRdData(bufRdData)
  );
endmodule

// File: tb/spi_adc_pacer_test.sv
`timescale 1ns/1ps
module spi_adc_pacer_test;
  localparam time TCLK = 8ns;

  logic        clk = 0, rstN = 0, regWe = 0;
  logic [2:0]  regAddr = 0;
  logic [31:0] regWdata = 0, regRdata, bufRdData;
  logic        irqDone, spiSclk, spiCsN, spiMiso;
  logic [10:0] bufRdAddr = 0;

  int checks = 0, failures = 0, blocksDone = 0;

  always #(TCLK/2) clk = ~clk;

  spi_adc_pacer uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqDone(irqDone),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMiso(spiMiso),
    .bufRdAddr(bufRdAddr), .bufRdData(bufRdData)
  );

  // ---------------- ADC model and line monitor ----------------
  bit cphaTb = 0;
  int convCnt = 0, bitPos = 99, lowRises = 0, frameRises = 0, lastLowRises = 0;
  time lastFall = 0, fallGap = 0, riseT = 0, highTime = 0;
  logic [21:0] curSamp = '0;
  logic prevCs = 1'b1, prevSclk = 1'b0;

  function automatic logic [21:0] expSamp(int n);
    logic [31:0] v;
    v = (32'(n) + 32'd1) * 32'h0002_9E37 ^ 32'h0015_A5A3;
    return v[21:0];
  endfunction

  assign spiMiso = (spiCsN || bitPos < 0 || bitPos > 21) ? 1'b1 : curSamp[21 - bitPos];

  always @(spiCsN or spiSclk) begin
    if (prevCs === 1'b1 && spiCsN === 1'b0) begin
      fallGap = $time - lastFall;
      lastFall = $time;
      frameRises = 0;
      lowRises = 0;
      curSamp = expSamp(convCnt);
      convCnt++;
      bitPos = cphaTb ? -1 : 0;
    end
    if (prevCs === 1'b0 && spiCsN === 1'b1) lastLowRises = lowRises;
    if (prevSclk === 1'b0 && spiSclk === 1'b1) begin
      riseT = $time;
      frameRises++;
      if (!spiCsN) lowRises++;
      if (cphaTb && !spiCsN) bitPos++;
    end
    if (prevSclk === 1'b1 && spiSclk === 1'b0) begin
      highTime = $time - riseT;
      if (!cphaTb && !spiCsN) bitPos++;
    end
    prevCs = spiCsN;
    prevSclk = spiSclk;
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic bufRead(int a, output logic [31:0] d);
    @(negedge clk);
    bufRdAddr = 11'(a);
    @(negedge clk);
    d = bufRdData;
  endtask

  task automatic waitIrq(string req);
    int n = 0;
    while (!irqDone && n < 20000) begin @(negedge clk); n++; end
    check(irqDone === 1'b1, req, "block done interrupt", irqDone, 1);
    blocksDone++;
  endtask

  task automatic configure(int per, int dv, int len, logic [31:0] mode);
    regWrite(3'd1, per);
    regWrite(3'd2, dv);
    regWrite(3'd3, len);
    regWrite(3'd0, mode);
  endtask

  task automatic checkBlock(string req, int bankBase, int firstConv, int len);
    logic [31:0] d;
    for (int i = 0; i < len; i++) begin
      bufRead(bankBase + i, d);
      check(d === {10'd0, expSamp(firstConv + i)}, req, "stored sample", d,
            {10'd0, expSamp(firstConv + i)});
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] d;
    check(spiCsN === 1'b1, "R1", "chip select idle", spiCsN, 1);
    check(spiSclk === 1'b0, "R1", "serial clock idle", spiSclk, 0);
    check(irqDone === 1'b0, "R1", "interrupt idle", irqDone, 0);
    regRead(3'd1, d); check(d == 480, "R1", "PERIOD default", d, 480);
    regRead(3'd2, d); check(d == 1, "R1", "DIVHALF default", d, 1);
    regRead(3'd3, d); check(d == 1000, "R1", "BLOCKLEN default", d, 1000);
    regRead(3'd4, d); check(d == 0, "R1", "status default", d, 0);
  endtask

  task automatic t_narrow_pingpong;
    logic [31:0] d;
    int base, cc;
    configure(200, 2, 4, 0);
    base = convCnt;
    regWrite(3'd0, 32'h1);
    waitIrq("R7");
    check(fallGap == 200 * TCLK, "R3", "frame spacing", fallGap, 200 * TCLK);
    check(lastLowRises == 22, "R2", "clocks with select low", lastLowRises, 22);
    check(frameRises == 22, "R2", "clocks per frame", frameRises, 22);
    check(highTime == 2 * TCLK, "R11", "serial clock high phase", highTime, 2 * TCLK);
    regRead(3'd4, d);
    check(d[1:0] == 2'b01, "R7", "done with bank 0", d[1:0], 1);
    checkBlock("R4", 0, base, 4);
    regWrite(3'd4, 32'h0);
    check(irqDone === 1'b1, "R8", "write 0 keeps interrupt", irqDone, 1);
    regWrite(3'd4, 32'h1);
    check(irqDone === 1'b0, "R8", "write 1 clears interrupt", irqDone, 0);
    waitIrq("R7");
    regRead(3'd4, d);
    check(d[1] == 1'b1, "R7", "second block in bank 1", d[1], 1);
    checkBlock("R7", 1024, base + 4, 4);
    regWrite(3'd4, 32'h1);
    regWrite(3'd0, 32'h2);
    regRead(3'd4, d);
    check(d[3] == 1'b1, "R10", "still running after stop", d[3], 1);
    waitIrq("R10");
    regRead(3'd4, d);
    check(d[3] == 1'b0, "R10", "running clear after block", d[3], 0);
    check(d[1] == 1'b0, "R7", "third block back in bank 0", d[1], 0);
    checkBlock("R10", 0, base + 8, 4);
    regWrite(3'd4, 32'h1);
    cc = convCnt;
    repeat (1000) @(negedge clk);
    check(convCnt == cc, "R10", "no frames after stop", convCnt, cc);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    int base, bk;
    cphaTb = 1;
    configure(200, 3, 3, 32'h8);
    base = convCnt;
    regWrite(3'd0, 32'h9);
    regWrite(3'd0, 32'ha);
    bk = blocksDone % 2;
    waitIrq("R5");
    check(highTime == 3 * TCLK, "R11", "high phase DIVHALF=3", highTime, 3 * TCLK);
    regRead(3'd4, d);
    check(d[1] == 1'(bk), "R7", "bank alternates", d[1], bk);
    checkBlock("R5", bk * 1024, base, 3);
    regWrite(3'd4, 32'h1);
    cphaTb = 0;
  endtask

  task automatic t_wide;
    logic [31:0] d;
    int base, bk;
    configure(200, 2, 2, 32'h4);
    base = convCnt;
    regWrite(3'd0, 32'h5);
    regWrite(3'd0, 32'h6);
    bk = blocksDone % 2;
    waitIrq("R6");
    check(lastLowRises == 22, "R6", "clocks with select low", lastLowRises, 22);
    check(frameRises == 32, "R6", "clocks per wide frame", frameRises, 32);
    checkBlock("R6", bk * 1024, base, 2);
    regWrite(3'd4, 32'h1);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    configure(40, 2, 2, 32'h0);
    regWrite(3'd0, 32'h1);
    regWrite(3'd0, 32'h2);
    waitIrq("R9");
    regRead(3'd4, d);
    check(d[2] == 1'b1, "R9", "overrun flag set", d[2], 1);
    check(fallGap == 120 * TCLK, "R9", "dropped expiries spacing", fallGap, 120 * TCLK);
    regWrite(3'd4, 32'h1);
    regRead(3'd4, d);
    check(d[2] == 1'b1, "R9", "overrun sticky", d[2], 1);
    regWrite(3'd4, 32'h4);
    regRead(3'd4, d);
    check(d[2] == 1'b0, "R9", "overrun cleared", d[2], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_narrow_pingpong();
    t_falling();
    t_wide();
    t_overrun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule